// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block produces the reset for a microprocessor. It drives an active-high and an active-low copy of the same reset. Three things can start a reset: a supply-good flag from an external comparator, a watchdog that software must service with strobe falling edges, and an active-low pushbutton. Every reset is stretched to a minimum width. The stretch always counts from the last active cause, so a new cause during a hold starts the full hold again.

A mode pin chooses between two kinds of processor. For a volatile processor, loss of supply asserts reset at once. For a battery-backed processor, loss of supply does not assert reset, and a reset pulse is issued only when the supply comes back. In battery-backed mode an early-warning flag can also silence the watchdog and the pushbutton while it reports the sensed voltage below its threshold. All comparators are outside the block and reach it as synchronous flags. A free-running clock plus a millisecond tick enable form the timebase, and every duration is a parameter counted in ticks.

Top module: `supervisor_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `cpu_rst` is 1 and `cpu_rst_n` is 0. After `rst_n` rises with the supply good, reset releases on the HOLD_TICKS-th tick. `cpu_rst_n` is always the inverse of `cpu_rst`.
- R2: When `mode_bb` = 0 (volatile processor), a clock edge that samples `supply_ok` = 0 asserts reset, and reset stays asserted for as long as the supply is bad.
- R3: In either mode, reset releases on the HOLD_TICKS-th tick after the first clock edge that samples `supply_ok` back at 1.
- R4: The hold advances only on edges where `tick_ms` = 1. Without ticks, reset never releases.
- R5: A new cause arriving during a hold reloads the full hold, so the reset width is measured from the last cause.
- R6: The watchdog starts counting at the edge where reset goes inactive. If it sees no strobe falling edge for WDOG_TICKS ticks, it expires, and reset asserts one clock later for the full hold.
- R7: `strobe_in` passes through a two-flop synchronizer. A 1-to-0 transition clears the watchdog count on the third clock edge after the input changes. A rising transition has no effect.
- R8: `button_n` passes through a two-flop synchronizer. A press is accepted only after the synchronized level stays low for DEB_TICKS consecutive ticks; shorter pulses are ignored.
- R9: An accepted press asserts reset one edge later and holds it while the button stays down. The hold starts from the debounced release.
- R10: When `mode_bb` = 1 (battery-backed processor), a supply drop does not assert reset. The return of the supply asserts reset, on the first edge that samples it good, for the hold period.
- R11: The watchdog does not count and cannot expire while `supply_ok` = 0, in either mode.
- R12: When `mode_bb` = 1 and `early_ok` = 0, both the watchdog and the pushbutton are disabled; the watchdog restarts from zero once `early_ok` returns to 1. When `mode_bb` = 0, `early_ok` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | Timebase enable, one cycle per tick |
| supply_ok | input | 1 | Main supply within tolerance |
| early_ok | input | 1 | Early-warning sense above its threshold |
| mode_bb | input | 1 | 1 = battery-backed processor, 0 = volatile processor |
| strobe_in | input | 1 | Watchdog service strobe (asynchronous) |
| button_n | input | 1 | Pushbutton, active low (asynchronous) |
| cpu_rst | output | 1 | Reset, active high |
| cpu_rst_n | output | 1 | Reset, active low |

## Verification
The bench drives a tick on every edge, so each latency can be counted in edges:
- A supply drop in volatile mode shows on the outputs one edge later.
- A supply return releases reset HOLD_TICKS+1 edges after it is driven, because the edge that sees it reloads the hold.
- A watchdog expiry shows WDOG_TICKS+1 edges after the release.
- A strobe fall pushes that expiry back by its own delay plus three.
- A button press shows DEB_TICKS+3 edges after it is driven, and its release shows DEB_TICKS+2+HOLD_TICKS edges after it is driven.

The bench drives inputs one time unit after each rising edge and samples the outputs at the same point. It counts the edges from the stimulus to each output change and compares that count with the value the formulas give. The strobe delay is swept across the whole timeout, including the first delay that comes too late, and glitch widths on the button are swept up to the debounce length.

// File: rtl/supv_pkg.sv
// Shared types and helpers for the supervisory reset controller.
package supv_pkg;

    // One flag per reset cause feeding the hold stretcher.
    typedef struct packed {
        logic supply;
        logic wdog;
        logic button;
    } rst_cause_t;

    // Width needed to hold the values 0..max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/supv_sync2.sv
// Two-flop synchronizer for one asynchronous level.
// Assumes the input is a slow level or an edge that needs no pulse capture.
module supv_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;
    logic sync_q;

    // Shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/supv_debounce.sv
// Debouncer: the output level follows the synchronized input only after the
// input has differed from it for DEB_TICKS consecutive ticks.
// Assumes raw_in is already synchronous to clk; the idle level is high.
module supv_debounce #(
    parameter int DEB_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw_in,
    output logic level_out
);
    localparam int CW = supv_pkg::cnt_width(DEB_TICKS);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic          state_q;
    logic [CW-1:0] cnt_q;

    // Count ticks of disagreement and adopt the new level when the count completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= 1'b1;
            cnt_q   <= '0;
        end else if (raw_in == state_q) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q >= LAST) begin
                state_q <= raw_in;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level_out = state_q;

    AST_DEB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q) |-> ($past(raw_in) == state_q) && $past(tick)); // R8
endmodule

// File: rtl/supv_wdog.sv
// Watchdog timer: counts ticks while enabled and is cleared by each falling
// edge of the synchronized strobe. Issues a one-cycle expiry pulse after
// TIMEOUT_TICKS ticks with no strobe fall.
// Assumes strobe_sync is already synchronous to clk.
module supv_wdog #(
    parameter int TIMEOUT_TICKS = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic strobe_sync,
    output logic expire
);
    localparam int CW = supv_pkg::cnt_width(TIMEOUT_TICKS);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic          strobe_prev_q;
    logic          strobe_fall;
    logic [CW-1:0] cnt_q;
    logic          expire_q;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_prev_q <= 1'b1;
        else        strobe_prev_q <= strobe_sync;
    end

    assign strobe_fall = strobe_prev_q & ~strobe_sync;

    // Advance the timeout count; clear it when disabled or on a strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || strobe_fall) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q >= LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    // Register the expiry pulse on the tick that completes the count.
    always_ff @(posedge clk) begin
        if (!rst_n) expire_q <= 1'b0;
        else        expire_q <= enable && !strobe_fall && tick && (cnt_q >= LAST);
    end

    assign expire = expire_q;

    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_fall |=> (cnt_q == '0) && !expire_q); // R7
    AST_WDOG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt_q == '0) && !expire_q); // R11
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R6
endmodule

// File: rtl/supv_stretch.sv
// Reset hold stretcher: any cause asserts the reset and loads HOLD_TICKS.
// Once no cause is present, the count falls on each tick and the reset
// releases when it reaches zero. Asserted out of reset (power-on hold).
// Assumes HOLD_TICKS >= 1.
module supv_stretch #(
    parameter int HOLD_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cause,
    output logic rst_active
);
    localparam int CW = supv_pkg::cnt_width(HOLD_TICKS);
    localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);

    logic          act_q;
    logic [CW-1:0] cnt_q;

    // Reload on any cause; otherwise count the hold down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || cause) begin
            act_q <= 1'b1;
            cnt_q <= FULL;
        end else if (act_q && tick) begin
            if (cnt_q <= CW'(1)) begin
                act_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign rst_active = act_q;

    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_q) |-> $past(tick) && !$past(cause)); // R4
    AST_CAUSE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> act_q && (cnt_q == FULL)); // R5
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_q && !cause) |=> !act_q); // R5
endmodule

// File: rtl/supervisor_reset_ctrl.sv
// Supervisory reset controller top. It combines the supply flag, the
// watchdog expiry and the debounced pushbutton into the reset causes, and
// applies the processor-mode rules for supply loss and early warning.
// Assumes supply_ok, early_ok and mode_bb are synchronous to clk;
// strobe_in and button_n may be asynchronous.
module supervisor_reset_ctrl #(
    parameter int HOLD_TICKS = 100,
    parameter int WDOG_TICKS = 400,
    parameter int DEB_TICKS  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic supply_ok,
    input  logic early_ok,
    input  logic mode_bb,
    input  logic strobe_in,
    input  logic button_n,
    output logic cpu_rst,
    output logic cpu_rst_n
);
    import supv_pkg::*;

    logic       strobe_s;
    logic       button_s;
    logic       button_lvl;
    logic       supply_prev_q;
    logic       supply_rise;
    logic       bb_quiet;
    logic       wd_enable;
    logic       wd_expire;
    logic       rst_active;
    rst_cause_t cause;

    supv_sync2 #(.RST_VAL(1'b1)) strobe_sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(strobe_in), .sync_out(strobe_s));

    supv_sync2 #(.RST_VAL(1'b1)) button_sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(button_n), .sync_out(button_s));

    supv_debounce #(.DEB_TICKS(DEB_TICKS)) button_deb_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms),
        .raw_in(button_s), .level_out(button_lvl));

    // Track the previous supply flag to find its return.
    always_ff @(posedge clk) begin
        if (!rst_n) supply_prev_q <= 1'b1;
        else        supply_prev_q <= supply_ok;
    end

    assign supply_rise = supply_ok & ~supply_prev_q;
    assign bb_quiet    = mode_bb & ~early_ok;

    // Form the reset causes under the processor-mode rules.
    always_comb begin
        cause.supply = (~supply_ok & ~mode_bb) | supply_rise;
        cause.wdog   = wd_expire;
        cause.button = ~button_lvl & ~bb_quiet;
    end

    assign wd_enable = ~rst_active & supply_ok & ~bb_quiet;

    supv_wdog #(.TIMEOUT_TICKS(WDOG_TICKS)) wdog_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms), .enable(wd_enable),
        .strobe_sync(strobe_s), .expire(wd_expire));

    supv_stretch #(.HOLD_TICKS(HOLD_TICKS)) stretch_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms),
        .cause(|cause), .rst_active(rst_active));

    assign cpu_rst   = rst_active;
    assign cpu_rst_n = ~rst_active;

    AST_SUPPLY_LOW_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok && !mode_bb) |=> cpu_rst && !cpu_rst_n); // R2
    AST_BB_DROP_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bb && !supply_ok && !wd_expire && !cause.button && !cpu_rst) |=> !cpu_rst); // R10
    AST_BB_QUIET_BUTTON: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_quiet && !cpu_rst && supply_ok && supply_prev_q && !wd_expire) |=> !cpu_rst); // R12
endmodule

// File: tb/supervisor_reset_ctrl_tb_top.sv
// Self-checking bench for supervisor_reset_ctrl with a small configuration.
// A tick is applied on every edge unless a test turns it off. Inputs are
// driven and outputs sampled one time unit after each rising edge.
module supervisor_reset_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 3;
    localparam int WDOG = 24;
    localparam int DEB  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b1;
    logic supply_ok = 1'b1;
    logic early_ok = 1'b1;
    logic mode_bb = 1'b0;
    logic strobe_in = 1'b1;
    logic button_n = 1'b1;
    logic cpu_rst;
    logic cpu_rst_n;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    supervisor_reset_ctrl #(.HOLD_TICKS(HOLD), .WDOG_TICKS(WDOG), .DEB_TICKS(DEB)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .supply_ok(supply_ok),
        .early_ok(early_ok), .mode_bb(mode_bb), .strobe_in(strobe_in),
        .button_n(button_n), .cpu_rst(cpu_rst), .cpu_rst_n(cpu_rst_n));

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Count edges until cpu_rst reaches the given level (capped).
    task automatic edges_until(input logic lvl, input int cap, output int n);
        n = 0;
        while (cpu_rst !== lvl && n < cap) begin
            step();
            n++;
        end
    endtask

    // Step a number of edges; report how many edges saw cpu_rst differ from lvl.
    task automatic hold_level(input logic lvl, input int edges, output int bad);
        bad = 0;
        for (int i = 0; i < edges; i++) begin
            step();
            if (cpu_rst !== lvl || cpu_rst_n !== ~lvl) bad++;
        end
    endtask

    // Apply reset in a given mode. On return, rst_n has just been released.
    task automatic do_reset(input logic bb);
        rst_n = 1'b0; mode_bb = bb; supply_ok = 1'b1; early_ok = 1'b1;
        strobe_in = 1'b1; button_n = 1'b1; tick_ms = 1'b1;
        step(); step(); step();
        rst_n = 1'b1;
    endtask

    // Reset and wait for the power-on hold to end; the return point is the release edge.
    task automatic reset_and_release(input logic bb);
        int n;
        do_reset(bb);
        edges_until(1'b0, 50, n);
        check("R1 power-on hold edges", n, HOLD);
    endtask

    initial begin : main
        int n;
        int bad;
        // R1: reset state and power-on hold
        rst_n = 1'b0;
        step(); step();
        check("R1 cpu_rst in reset", int'(cpu_rst), 1);
        check("R1 cpu_rst_n in reset", int'(cpu_rst_n), 0);
        reset_and_release(1'b0);
        check("R1 cpu_rst_n complement after release", int'(cpu_rst_n), 1);

        // R6: watchdog expiry and its hold
        edges_until(1'b1, 100, n);
        check("R6 watchdog expiry edges after release", n, WDOG + 1);
        edges_until(1'b0, 50, n);
        check("R6 watchdog reset hold edges", n, HOLD);

        // R4: no tick, no release
        do_reset(1'b0);
        tick_ms = 1'b0;
        hold_level(1'b1, 10, bad);
        check("R4 hold frozen without tick", bad, 0);
        tick_ms = 1'b1;
        edges_until(1'b0, 50, n);
        check("R4 release after ticks resume", n, HOLD);

        // R5: a supply glitch during the power-on hold reloads it
        do_reset(1'b0);
        step();
        supply_ok = 1'b0;
        step();
        supply_ok = 1'b1;
        edges_until(1'b0, 50, n);
        check("R5 reload on cause during hold", n, 1 + HOLD);

        // R7: sweep the strobe fall delay across the whole timeout
        for (int d = 0; d <= WDOG - 2; d++) begin
            reset_and_release(1'b0);
            for (int k = 0; k < d; k++) step();
            strobe_in = 1'b0;
            edges_until(1'b1, 200, n);
            if (d <= WDOG - 3) check("R7 strobe fall restarts timeout", n, WDOG + 4);
            else               check("R7 late strobe fall does not prevent expiry", n, WDOG + 1 - d);
            strobe_in = 1'b1;
        end

        // R7: a rising strobe edge alone does not restart the count
        reset_and_release(1'b0);
        strobe_in = 1'b0;
        step(); step(); step();
        strobe_in = 1'b1;
        step(); step();
        edges_until(1'b1, 200, n);
        check("R7 rising strobe edge ignored", n, WDOG + 1 - 2);

        // R2 and R3: volatile supply loss and return
        reset_and_release(1'b0);
        supply_ok = 1'b0;
        step();
        check("R2 reset asserted one edge after supply drop", int'(cpu_rst), 1);
        hold_level(1'b1, WDOG + 5, bad);
        check("R2 reset held while supply bad", bad, 0);
        supply_ok = 1'b1;
        edges_until(1'b0, 50, n);
        check("R3 volatile release after supply return", n, HOLD + 1);

        // R10, R11 and R3: battery-backed supply loss and return
        reset_and_release(1'b1);
        supply_ok = 1'b0;
        hold_level(1'b0, WDOG + 5, bad);
        check("R10 no reset on supply drop in battery mode", bad, 0);
        check("R11 watchdog silent while supply bad", bad, 0);
        supply_ok = 1'b1;
        step();
        check("R10 reset asserted on supply return", int'(cpu_rst), 1);
        edges_until(1'b0, 50, n);
        check("R3 battery-mode release after supply return", n, HOLD);

        // R8 and R9: debounced press and release
        reset_and_release(1'b0);
        button_n = 1'b0;
        edges_until(1'b1, 50, n);
        check("R9 press asserts reset", n, DEB + 3);
        hold_level(1'b1, 6, bad);
        check("R9 reset held while pressed", bad, 0);
        button_n = 1'b1;
        edges_until(1'b0, 50, n);
        check("R9 hold starts at debounced release", n, DEB + 2 + HOLD);

        // R8: glitches shorter than the debounce length are ignored
        for (int w = 1; w < DEB; w++) begin
            reset_and_release(1'b0);
            button_n = 1'b0;
            for (int k = 0; k < w; k++) step();
            button_n = 1'b1;
            hold_level(1'b0, 12, bad);
            check("R8 short button glitch ignored", bad, 0);
        end

        // R8: a low pulse of exactly the debounce length is accepted
        reset_and_release(1'b0);
        button_n = 1'b0;
        for (int k = 0; k < DEB; k++) step();
        button_n = 1'b1;
        edges_until(1'b1, 12, n);
        check("R8 full-length press accepted", int'(cpu_rst), 1);
        edges_until(1'b0, 50, n);

        // R12: battery mode with early warning low silences watchdog and button
        reset_and_release(1'b1);
        early_ok = 1'b0;
        hold_level(1'b0, WDOG + 5, bad);
        check("R12 watchdog disabled by early warning", bad, 0);
        button_n = 1'b0;
        hold_level(1'b0, 12, bad);
        check("R12 button disabled by early warning", bad, 0);
        button_n = 1'b1;
        hold_level(1'b0, DEB + 3, bad);
        check("R12 release ignored while disabled", bad, 0);
        early_ok = 1'b1;
        edges_until(1'b1, 100, n);
        check("R12 watchdog restarts when warning clears", n, WDOG + 1);
        edges_until(1'b0, 50, n);

        // R12: early warning has no effect in volatile mode
        reset_and_release(1'b0);
        early_ok = 1'b0;
        edges_until(1'b1, 100, n);
        check("R12 volatile watchdog ignores warning", n, WDOG + 1);
        edges_until(1'b0, 50, n);
        early_ok = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL run timeout (all R): actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule